// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address by walking a tree of translation tables held in memory. A request carries the address and three qualifiers (store, instruction fetch, privileged). Alongside it the block takes the current process identifier and a pointer register that locates the process table. The walker first fetches the process-table entry. That entry gives the tree size, the root index width and the root base. The walker then checks that the address lies inside the tree and descends through directory levels until it reaches a leaf. At the leaf it applies the permission and reference/change rules and forms the real address.

Each level's index width comes from the entry just read, so both the depth and the index slice taken from the address vary from one walk to the next. Every table address is built by merging a base with index bits under a mask. Memory is reached through a single 64-bit read port: the request is held until it is acknowledged. The walker handles one translation at a time. At the end it pulses `done` with an error code and, on success, a real address.

Top module: `radix_walker`

## Requirements
- R1: A request is taken when `reqValid` is high and `busy` is low. `busy` goes high the following cycle and stays high up to and including the `done` cycle, then drops. Any `reqValid` seen while `busy` is high is ignored and does not alter the running walk.
- R2: `memReq` is high only during a walk. Once raised, it stays high with `memAddr` stable until a cycle with `memAck` high. `memData` is consumed in that cycle. Only one read is outstanding at a time.
- R3: The first read goes to {8'h00, ptr[55:36], (ptr[35:12] & ~m24) | (epid[31:8] & m24), epid[7:0], 4'h0}, where `ptr` is `tablePtr` and m24 holds ptr[4:0] low ones. epid is zero when address bit 63 is 1 and `pidReg` otherwise.
- R4: From the process-table entry, the tree size is {d[62:61], d[7:5]}. The walk ends with code 3 (segment) if address bit 63 differs from bit 62, or if any bit of addr[61:31] lies above the lowest tree-size positions and is set. This check takes precedence over R5.
- R5: The root index width is d[4:0]. A value below 5, above 16, or above tree size + 19 ends the walk with code 2 (badtree). Otherwise the working shift becomes tree size + 19 − width and the base becomes {d[55:8], 8'h00}.
- R6: Each directory read goes to {8'h00, base[55:19], (base[18:3] & ~m) | (ix & m), 3'b000}. Here m holds as many low ones as the current index width, and ix is the low 16 bits of addr[61:12] shifted right by the working shift.
- R7: An entry with bit 63 clear ends the walk with code 1 (invalid).
- R8: A valid entry with bit 62 clear is a directory. Its width d[4:0] must be within 5..16 and no greater than the working shift, else code 2. Otherwise the shift drops by that width, the base becomes {d[55:8], 8'h00}, and the walk continues.
- R9: If the eighth directory-level read still returns a directory, the walk ends with code 2. This caps a walk at nine memory reads.
- R10: A leaf (bit 62 set) passes permissions only if the request is privileged or d[3] is 0, and also: for data, d[1] | (d[2] & ~store); for fetch, d[0] & ~d[5]. A failure gives code 4 (permission).
- R11: A leaf that passes R10 also needs d[8] & (d[7] | ~store), else code 5 (RC). When both checks fail, code 4 is reported.
- R12: A leaf passing both checks gives code 0 and `realAddr` = {8'h00, (d[55:12] & ~fm) | (addr[55:12] & fm), d[11:0]}, where fm holds as many low ones as the working shift.
- R13: `done` is a one-cycle pulse. `errCode` is valid in that cycle and only takes values 0 to 5. No memory read is requested in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a translation |
| reqAddr | input | 64 | Effective address to translate |
| reqStore | input | 1 | Access is a store |
| reqFetch | input | 1 | Access is an instruction fetch |
| reqPriv | input | 1 | Access is privileged |
| pidReg | input | 32 | Current process identifier |
| tablePtr | input | 64 | Process-table base and size pointer |
| busy | output | 1 | A walk is in progress |
| memReq | output | 1 | Memory read request |
| memAddr | output | 64 | Memory read address |
| memAck | input | 1 | Read data valid this cycle |
| memData | input | 64 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| realAddr | output | 64 | Translated real address when errCode is 0 |
| errCode | output | 3 | 0 ok, 1 invalid, 2 badtree, 3 segment, 4 permission, 5 RC |

## Verification
The permission check and the reference/change check are both decided from the same leaf entry, in the acknowledge cycle. The bench sweeps every combination of the seven leaf bits they read, against each store, fetch and privilege setting. This puts both failures in one cycle many times, and a bench model requires code 4 whenever both fail. The segment check and the root-width check also collide in the process-table acknowledge cycle. A directed walk with an out-of-range address and an undersized root width must report code 3.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

  localparam int WORD_W   = 64;
  localparam int PID_W    = 32;
  localparam int MASK_W   = 44;
  localparam int SEG_BIAS = 19;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_INVALID = 3'd1,
    ERR_BADTREE = 3'd2,
    ERR_SEGMENT = 3'd3,
    ERR_PERM    = 3'd4,
    ERR_RC      = 3'd5
  } walkErr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selRoot;
    logic capture;
    logic takeRoot;
    logic takeNext;
    logic takeLeaf;
  } walkStrobe_t;

  // decoded conditions from datapath to control
  typedef struct packed {
    logic segFail;
    logic rootBad;
    logic entValid;
    logic entLeaf;
    logic nextBad;
    logic permOk;
    logic rcOk;
  } walkFlags_t;

  function automatic logic [MASK_W-1:0] lowOnes(input logic [5:0] n);
    logic [MASK_W-1:0] m;
    for (int i = 0; i < MASK_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

endpackage

// File: rtl/radix_walk_dp.sv
module radix_walk_dp
  import radix_walk_pkg::*;
#(
  parameter int MIN_IDX = 5,
  parameter int MAX_IDX = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [WORD_W-1:0] reqAddr,
  input  logic              reqStore,
  input  logic              reqFetch,
  input  logic              reqPriv,
  input  logic [PID_W-1:0]  pidReg,
  input  logic [WORD_W-1:0] tablePtr,
  input  logic [WORD_W-1:0] memData,
  output walkFlags_t        flags,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] realAddr
);

  logic [WORD_W-1:0] addrQ, ptrQ, realQ;
  logic [PID_W-1:0]  pidQ;
  logic              storeQ, fetchQ, privQ;
  logic [5:0]        shiftQ;
  logic [4:0]        sizeQ;
  logic [55:0]       baseQ;

  // entry decode
  logic [4:0]        treeSz, entSize;
  logic [5:0]        rootLimit;
  logic [MASK_W-1:0] segMask, tblMask, idxMask, leafMask;
  logic [PID_W-1:0]  effPid;
  logic [49:0]       pageNum, pageShifted;
  logic [15:0]       addrSh;
  logic [WORD_W-1:0] prtAddr, dirAddr;
  logic              unusedOk;

  assign treeSz    = {memData[62:61], memData[7:5]};
  assign entSize   = memData[4:0];
  assign rootLimit = {1'b0, treeSz} + 6'(SEG_BIAS);
  assign segMask   = lowOnes({1'b0, treeSz});
  assign tblMask   = lowOnes({1'b0, ptrQ[4:0]});
  assign idxMask   = lowOnes({1'b0, sizeQ});
  assign leafMask  = lowOnes(shiftQ);

  assign effPid      = addrQ[63] ? '0 : pidQ;
  assign pageNum     = addrQ[61:12];
  assign pageShifted = pageNum >> shiftQ;
  assign addrSh      = pageShifted[15:0];

  assign prtAddr = {8'h00, ptrQ[55:36],
                    (ptrQ[35:12] & ~tblMask[23:0]) | (effPid[31:8] & tblMask[23:0]),
                    effPid[7:0], 4'h0};
  assign dirAddr = {8'h00, baseQ[55:19],
                    (baseQ[18:3] & ~idxMask[15:0]) | (addrSh & idxMask[15:0]),
                    3'b000};
  assign memAddr = strobe.selRoot ? prtAddr : dirAddr;

  function automatic logic sizeBad(input logic [4:0] n, input logic [5:0] lim);
    return (n < 5'(MIN_IDX)) || (n > 5'(MAX_IDX)) || ({1'b0, n} > lim);
  endfunction

  always_comb begin
    flags.segFail  = (addrQ[63] != addrQ[62]) || (|(addrQ[61:31] & ~segMask[30:0]));
    flags.rootBad  = sizeBad(entSize, rootLimit);
    flags.nextBad  = sizeBad(entSize, shiftQ);
    flags.entValid = memData[63];
    flags.entLeaf  = memData[62];
    flags.permOk   = (privQ || !memData[3]) &&
                     (fetchQ ? (memData[0] && !memData[5])
                             : (memData[1] || (memData[2] && !storeQ)));
    flags.rcOk     = memData[8] && (memData[7] || !storeQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      ptrQ   <= '0;
      pidQ   <= '0;
      storeQ <= 1'b0;
      fetchQ <= 1'b0;
      privQ  <= 1'b0;
      shiftQ <= '0;
      sizeQ  <= '0;
      baseQ  <= '0;
      realQ  <= '0;
    end else begin
      if (strobe.capture) begin
        addrQ  <= reqAddr;
        ptrQ   <= tablePtr;
        pidQ   <= pidReg;
        storeQ <= reqStore;
        fetchQ <= reqFetch;
        privQ  <= reqPriv;
        realQ  <= '0;
      end
      if (strobe.takeRoot) begin
        shiftQ <= rootLimit - {1'b0, entSize};
        sizeQ  <= entSize;
        baseQ  <= {memData[55:8], 8'h00};
      end
      if (strobe.takeNext) begin
        shiftQ <= shiftQ - {1'b0, entSize};
        sizeQ  <= entSize;
        baseQ  <= {memData[55:8], 8'h00};
      end
      if (strobe.takeLeaf) begin
        realQ <= {8'h00, (memData[55:12] & ~leafMask) | (addrQ[55:12] & leafMask),
                  memData[11:0]};
      end
    end
  end

  assign realAddr = realQ;
  assign unusedOk = ^{memData[61:56], addrQ[11:0], ptrQ[63:56], ptrQ[11:5]};

endmodule

// File: rtl/radix_walk_ctrl.sv
module radix_walk_ctrl
  import radix_walk_pkg::*;
#(
  parameter int MAX_LEVELS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memAck,
  input  walkFlags_t  flags,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        memReq,
  output logic        done,
  output logic [2:0]  errCode
);

  localparam int LVL_W = (MAX_LEVELS > 2) ? $clog2(MAX_LEVELS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ROOT, ST_DIR, ST_FIN} walkState_e;

  walkState_e       stateQ;
  walkErr_e         errQ;
  logic [LVL_W-1:0] levelQ;
  logic             lastLevel;

  assign lastLevel = (levelQ == LVL_W'(MAX_LEVELS - 1));

  always_comb begin
    strobe          = '0;
    strobe.selRoot  = (stateQ == ST_ROOT);
    strobe.capture  = (stateQ == ST_IDLE) && reqValid;
    strobe.takeRoot = (stateQ == ST_ROOT) && memAck && !flags.segFail && !flags.rootBad;
    strobe.takeNext = (stateQ == ST_DIR) && memAck && flags.entValid && !flags.entLeaf &&
                      !flags.nextBad && !lastLevel;
    strobe.takeLeaf = (stateQ == ST_DIR) && memAck && flags.entValid && flags.entLeaf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= ERR_NONE;
      levelQ <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (reqValid) begin
            stateQ <= ST_ROOT;
            errQ   <= ERR_NONE;
            levelQ <= '0;
          end
        end
        ST_ROOT: begin
          if (memAck) begin
            if (flags.segFail) begin
              errQ   <= ERR_SEGMENT;
              stateQ <= ST_FIN;
            end else if (flags.rootBad) begin
              errQ   <= ERR_BADTREE;
              stateQ <= ST_FIN;
            end else begin
              stateQ <= ST_DIR;
            end
          end
        end
        ST_DIR: begin
          if (memAck) begin
            if (!flags.entValid) begin
              errQ   <= ERR_INVALID;
              stateQ <= ST_FIN;
            end else if (flags.entLeaf) begin
              if (!flags.permOk)     errQ <= ERR_PERM;
              else if (!flags.rcOk)  errQ <= ERR_RC;
              else                   errQ <= ERR_NONE;
              stateQ <= ST_FIN;
            end else if (flags.nextBad || lastLevel) begin
              errQ   <= ERR_BADTREE;
              stateQ <= ST_FIN;
            end else begin
              levelQ <= levelQ + 1'b1;
            end
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (stateQ != ST_IDLE);
  assign memReq  = (stateQ == ST_ROOT) || (stateQ == ST_DIR);
  assign done    = (stateQ == ST_FIN);
  assign errCode = errQ;

endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walk_pkg::*;
#(
  parameter int MAX_LEVELS = 8,
  parameter int MIN_IDX    = 5,
  parameter int MAX_IDX    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [63:0] reqAddr,
  input  logic        reqStore,
  input  logic        reqFetch,
  input  logic        reqPriv,
  input  logic [31:0] pidReg,
  input  logic [63:0] tablePtr,
  output logic        busy,
  output logic        memReq,
  output logic [63:0] memAddr,
  input  logic        memAck,
  input  logic [63:0] memData,
  output logic        done,
  output logic [63:0] realAddr,
  output logic [2:0]  errCode
);

  walkStrobe_t strobe;
  walkFlags_t  flags;

  radix_walk_ctrl #(.MAX_LEVELS(MAX_LEVELS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck), .flags(flags),
    .strobe(strobe), .busy(busy), .memReq(memReq), .done(done), .errCode(errCode)
  );

  radix_walk_dp #(.MIN_IDX(MIN_IDX), .MAX_IDX(MAX_IDX)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqStore(reqStore),
    .reqFetch(reqFetch), .reqPriv(reqPriv), .pidReg(pidReg), .tablePtr(tablePtr),
    .memData(memData), .flags(flags), .memAddr(memAddr), .realAddr(realAddr)
  );

endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
  parameter int MAX_LEVELS = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        busy,
  input logic        memReq,
  input logic [63:0] memAddr,
  input logic        memAck,
  input logic        done,
  input logic [2:0]  errCode
);

  localparam int CNT_W = $clog2(MAX_LEVELS + 3) + 1;

  logic [CNT_W-1:0] readsQ;

  always_ff @(posedge clk) begin
    if (!rstN)                  readsQ <= '0;
    else if (reqValid && !busy) readsQ <= '0;
    else if (memReq && memAck)  readsQ <= readsQ + 1'b1;
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);
  p_done_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  p_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);
  p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));
  p_depth_cap_r9: assert property (@(posedge clk) disable iff (!rstN)
    readsQ <= CNT_W'(MAX_LEVELS + 1));
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_code_range_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errCode <= 3'd5));
  p_quiet_done_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

endmodule

bind radix_walker radix_walker_chk #(.MAX_LEVELS(MAX_LEVELS)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .memReq(memReq),
  .memAddr(memAddr), .memAck(memAck), .done(done), .errCode(errCode)
);

// File: tb/tb_radix_walker.sv
`timescale 1ns/1ps
module tb_radix_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        reqStore = 1'b0, reqFetch = 1'b0, reqPriv = 1'b0;
  logic [31:0] pidReg = '0;
  logic [63:0] tablePtr = '0;
  logic        busy, memReq, done;
  logic [63:0] memAddr, realAddr;
  logic        memAck = 1'b0;
  logic [63:0] memData = '0;
  logic [2:0]  errCode;

  int checks = 0, fails = 0;
  int lat = 0, waitCnt = 0, readCnt = 0;

  logic [63:0] mem [logic [63:0]];

  localparam logic [63:0] STD_PTR = 64'h0000_0000_0100_0000;
  localparam logic [11:0] RW_LOW  = 12'h187;   // bits 0,1,2,7,8

  radix_walker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqStore(reqStore),
    .reqFetch(reqFetch), .reqPriv(reqPriv), .pidReg(pidReg), .tablePtr(tablePtr),
    .busy(busy), .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .done(done), .realAddr(realAddr), .errCode(errCode)
  );

  always #5 clk = ~clk;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // memory responder, driven away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0; waitCnt = 0;
    end else if (memAck) begin
      memAck = 1'b0; waitCnt = 0;
    end else if (memReq) begin
      if (waitCnt >= lat) begin
        memAck = 1'b1; memData = rd(memAddr); readCnt++;
      end else waitCnt++;
    end
  end

  function automatic logic [63:0] ones(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [63:0] mkDir(input logic [63:0] base, input logic [4:0] n);
    logic [63:0] e = '0;
    e[63] = 1'b1; e[55:8] = base[55:8]; e[4:0] = n;
    return e;
  endfunction

  function automatic logic [63:0] mkPrt(input logic [4:0] rts, input logic [63:0] base,
                                        input logic [4:0] n);
    logic [63:0] e = '0;
    e[62:61] = rts[4:3]; e[7:5] = rts[2:0]; e[55:8] = base[55:8]; e[4:0] = n;
    return e;
  endfunction

  function automatic logic [63:0] mkLeaf(input logic [43:0] rpn, input logic [11:0] low);
    return {8'h00, rpn, low} | 64'hC000_0000_0000_0000;
  endfunction

  // model derived from the requirements
  task automatic refWalk(input logic [63:0] a, input logic s, input logic f, input logic p,
                         output logic [2:0] e, output logic [63:0] ra, output int nr);
    logic [31:0] ep;
    logic [63:0] m, d, base, pa;
    logic [4:0]  rts, mb;
    logic [5:0]  lim, sh;
    logic [49:0] pn;
    logic [15:0] ix;
    logic        ok, rc;
    e = 3'd2; ra = '0; nr = 1;
    ep = a[63] ? 32'h0 : pidReg;
    m  = ones(int'(tablePtr[4:0]));
    pa = {8'h00, tablePtr[55:36], (tablePtr[35:12] & ~m[23:0]) | (ep[31:8] & m[23:0]),
          ep[7:0], 4'h0};
    d = rd(pa);
    rts = {d[62:61], d[7:5]}; mb = d[4:0]; lim = 6'(rts) + 6'd19;
    m = ones(int'(rts));
    if (a[63] != a[62] || (|(a[61:31] & ~m[30:0]))) begin e = 3'd3; return; end
    if (mb < 5 || mb > 16 || 6'(mb) > lim) begin e = 3'd2; return; end
    sh = lim - 6'(mb); base = {8'h00, d[55:8], 8'h00};
    for (int lvl = 0; lvl < 8; lvl++) begin
      pn = a[61:12] >> sh; ix = pn[15:0]; m = ones(int'(mb));
      pa = {8'h00, base[55:19], (base[18:3] & ~m[15:0]) | (ix & m[15:0]), 3'b000};
      d = rd(pa); nr++;
      if (!d[63]) begin e = 3'd1; return; end
      if (d[62]) begin
        ok = (p || !d[3]) && (f ? (d[0] && !d[5]) : (d[1] || (d[2] && !s)));
        rc = d[8] && (d[7] || !s);
        e  = !ok ? 3'd4 : (!rc ? 3'd5 : 3'd0);
        m  = ones(int'(sh));
        ra = {8'h00, (d[55:12] & ~m[43:0]) | (a[55:12] & m[43:0]), d[11:0]};
        return;
      end
      mb = d[4:0];
      if (mb < 5 || mb > 16 || 6'(mb) > sh) begin e = 3'd2; return; end
      sh = sh - 6'(mb); base = {8'h00, d[55:8], 8'h00};
    end
    e = 3'd2;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic runWalk(input logic [63:0] a, input logic s, input logic f, input logic p,
                         output logic [2:0] e, output logic [63:0] ra, output int nr);
    int t;
    @(negedge clk);
    reqAddr = a; reqStore = s; reqFetch = f; reqPriv = p; reqValid = 1'b1; readCnt = 0;
    @(negedge clk);
    reqValid = 1'b0;
    t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1: walk never finished actual busy=%0b expected done=1", busy);
    end
    e = errCode; ra = realAddr; nr = readCnt;
  endtask

  // fill the standard four-level chain for address a
  task automatic buildStd(input logic [63:0] a, input logic [63:0] leaf, input int leafLvl);
    mem[STD_PTR] = mkPrt(5'd21, 64'h30000, 5'd13);
    mem[64'h30000 + {a[51:39], 3'b0}] = mkDir(64'h40000, 5'd9);
    mem[64'h40000 + {a[38:30], 3'b0}] = (leafLvl == 2) ? leaf : mkDir(64'h50000, 5'd9);
    mem[64'h50000 + {a[29:21], 3'b0}] = mkDir(64'h60000, 5'd9);
    mem[64'h60000 + {a[20:12], 3'b0}] = leaf;
  endtask

  task automatic compareRef(input string tag, input logic [63:0] a, input logic s,
                            input logic f, input logic p);
    logic [2:0] e, ee; logic [63:0] ra, er; int nr, en;
    runWalk(a, s, f, p, e, ra, nr);
    refWalk(a, s, f, p, ee, er, en);
    chk({tag, " code"}, 64'(e), 64'(ee));
    chk({tag, " reads"}, 64'(nr), 64'(en));
    if (ee == 3'd0) chk({tag, " addr"}, ra, er);
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] e; logic [63:0] ra, a, leaf; int nr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", 64'(busy), 0);
    chk("R13 reset done", 64'(done), 0);
    chk("R2 reset memReq", 64'(memReq), 0);
    tablePtr = STD_PTR; pidReg = 32'h0;

    // R6 R12 R3: address sweep through four levels, real address hand formed
    for (int i = 0; i < 12; i++) begin
      mem.delete();
      lat = i % 3;
      a = ((64'h0000_5A5A_5A5A_5000 + 64'(i) * 64'h0000_0123_4567_8000)
           & 64'h000F_FFFF_FFFF_F000) | 64'(i * 37);
      leaf = mkLeaf(44'h00A_BCDE_0000 + 44'(i * 4099), RW_LOW);
      buildStd(a, leaf, 4);
      runWalk(a, i[0], 1'b0, 1'b0, e, ra, nr);
      chk("R12 sweep code", 64'(e), 0);
      chk("R12 sweep addr", ra, {8'h00, 44'h00A_BCDE_0000 + 44'(i * 4099), RW_LOW});
      chk("R6 sweep reads", 64'(nr), 5);
    end
    lat = 1;

    // R12: leaf at level two merges 18 address bits
    mem.delete();
    a = 64'h0000_1234_5678_9000;
    buildStd(a, mkLeaf(44'h123_4567_89AB, RW_LOW), 2);
    runWalk(a, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R12 large page code", 64'(e), 0);
    chk("R12 large page addr", ra,
        {8'h00, (44'h123_4567_89AB & ~44'h3FFFF) | (a[55:12] & 44'h3FFFF), RW_LOW});
    chk("R12 large page reads", 64'(nr), 3);

    // R10 R11: leaf bit sweep against every qualifier
    a = 64'h0000_0ABC_DEF1_2000;
    for (int k = 0; k < 128; k++) begin
      for (int q = 0; q < 8; q++) begin
        logic [11:0] low = '0;
        low[0] = k[0]; low[1] = k[1]; low[2] = k[2]; low[3] = k[3];
        low[5] = k[4]; low[7] = k[5]; low[8] = k[6];
        mem.delete();
        buildStd(a, mkLeaf(44'h000_0055_5000, low), 4);
        lat = 0;
        compareRef("R10 R11 leaf sweep", a, q[0], q[1], q[2]);
      end
    end
    lat = 1;
    // R11: both permission and RC failing reports permission
    mem.delete();
    buildStd(a, mkLeaf(44'h1, 12'h008), 4);
    runWalk(a, 1'b1, 1'b0, 1'b0, e, ra, nr);
    chk("R11 precedence", 64'(e), 4);
    mem.delete();
    buildStd(a, mkLeaf(44'h1, 12'h106), 4);
    runWalk(a, 1'b1, 1'b0, 1'b0, e, ra, nr);
    chk("R11 store without change bit", 64'(e), 5);

    // R7: invalid third-level entry
    mem.delete();
    buildStd(a, mkLeaf(44'h1, RW_LOW), 4);
    mem[64'h50000 + {a[29:21], 3'b0}] = 64'h3FFF_FFFF_FFFF_FFFF;
    runWalk(a, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R7 invalid code", 64'(e), 1);
    chk("R7 invalid reads", 64'(nr), 4);

    // R5: root width bounds
    mem.delete();
    mem[STD_PTR] = mkPrt(5'd21, 64'h30000, 5'd4);
    runWalk(a, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R5 root width 4", 64'(e), 2);
    chk("R5 root width 4 reads", 64'(nr), 1);
    mem[STD_PTR] = mkPrt(5'd21, 64'h30000, 5'd17);
    runWalk(a, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R5 root width 17", 64'(e), 2);
    mem.delete();
    mem[STD_PTR] = mkPrt(5'd21, 64'h80000, 5'd16);
    mem[64'h80000] = mkLeaf(44'hABC_0000_0000, RW_LOW);
    compareRef("R5 root width 16", 64'h0000_0000_1234_5000, 1'b0, 1'b0, 1'b0);

    // R8: directory width bounds
    mem.delete();
    buildStd(a, mkLeaf(44'h1, RW_LOW), 4);
    mem[64'h40000 + {a[38:30], 3'b0}] = mkDir(64'h50000, 5'd4);
    runWalk(a, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R8 dir width 4", 64'(e), 2);
    chk("R8 dir width 4 reads", 64'(nr), 3);
    mem[64'h40000 + {a[38:30], 3'b0}] = mkDir(64'h50000, 5'd17);
    runWalk(a, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R8 dir width 17", 64'(e), 2);
    mem[64'h40000 + {a[38:30], 3'b0}] = mkDir(64'h50000, 5'd9);
    mem[64'h60000 + {a[20:12], 3'b0}] = mkDir(64'h70000, 5'd5);
    runWalk(a, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R8 width above shift", 64'(e), 2);
    chk("R8 width above shift reads", 64'(nr), 5);

    // R4 R13: segment failures and precedence over root badtree
    mem.delete();
    buildStd(a, mkLeaf(44'h1, RW_LOW), 4);
    runWalk(64'h8000_0000_0000_1000, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R4 quadrant mismatch", 64'(e), 3);
    chk("R4 quadrant reads", 64'(nr), 1);
    runWalk(64'h0080_0000_0000_1000, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R4 bit above tree", 64'(e), 3);
    mem[STD_PTR] = mkPrt(5'd21, 64'h30000, 5'd4);
    runWalk(64'h0080_0000_0000_1000, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R4 segment before badtree", 64'(e), 3);

    // R9: self-referencing directory hits the depth cap
    mem.delete();
    mem[STD_PTR] = mkPrt(5'd31, 64'h90000, 5'd5);
    mem[64'h90000] = mkDir(64'h90000, 5'd5);
    runWalk(64'h0, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R9 depth code", 64'(e), 2);
    chk("R9 depth reads", 64'(nr), 9);

    // R3: process id indexes the table; quadrant 3 forces id zero
    mem.delete();
    tablePtr = STD_PTR | 64'd8; pidReg = 32'h0000_1203;
    a = 64'h0000_0000_0040_3000;
    buildStd(a, mkLeaf(44'h777, RW_LOW), 4);
    mem.delete(STD_PTR);
    mem[STD_PTR | 64'h12030] = mkPrt(5'd21, 64'h30000, 5'd13);
    runWalk(a, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R3 pid slot code", 64'(e), 0);
    chk("R3 pid slot addr", ra, {8'h00, 44'h777, RW_LOW});
    runWalk(a | 64'hC000_0000_0000_0000, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R3 forced zero pid", 64'(e), 2);
    mem[STD_PTR] = mkPrt(5'd21, 64'h30000, 5'd13);
    mem.delete(STD_PTR | 64'h12030);
    runWalk(a | 64'hC000_0000_0000_0000, 1'b0, 1'b0, 1'b0, e, ra, nr);
    chk("R3 zero pid slot", 64'(e), 0);
    tablePtr = STD_PTR; pidReg = 32'h0;

    // R1: a request during a walk is ignored
    mem.delete();
    a = 64'h0000_0000_0040_3000;
    buildStd(a, mkLeaf(44'h321, RW_LOW), 4);
    lat = 2;
    @(negedge clk);
    reqAddr = a; reqStore = 0; reqFetch = 0; reqPriv = 0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1 busy after accept", 64'(busy), 1);
    repeat (3) @(negedge clk);
    reqAddr = 64'h8000_0000_0000_0000; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    begin
      int t = 0;
      while (!done && t < 400) begin @(negedge clk); t++; end
    end
    chk("R1 ignored request code", 64'(errCode), 0);
    chk("R1 ignored request addr", realAddr, {8'h00, 44'h321, RW_LOW});
    @(negedge clk);
    chk("R1 busy released", 64'(busy), 0);
    chk("R13 done single cycle", 64'(done), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule